// File: doc/BRIEF.md
# Sequential Binary-to-Decimal Digit Converter

This block turns an unsigned binary number of configurable width into packed decimal digits, four bits per digit. It is iterative and uses the shift-and-add-3 method. A one-cycle start strobe captures the binary input. The block then does one correction-and-shift step per clock cycle. After exactly as many steps as the input has bits, it raises a single-cycle completion pulse and presents the digits on a registered output bus.

Internally there is one working register. Its upper part is split into 4-bit decimal digits and its lower part holds the binary operand. On each step, every digit greater than 4 first has 3 added to it, and then the whole register shifts left by one bit. After the last shift no correction is applied, and the digit field is the result. A start that arrives while a conversion is running is dropped.

Top module: `bcd_seq_conv`

## Requirements
- R1: While `rst_n` is low at a clock edge, `busy_o`, `done_o` and `bcd_o` become 0 at that edge.
- R2: A start (`start_i` high with `busy_o` low at a clock edge) captures `bin_i`. `busy_o` is high from the next cycle and stays high until the edge at which `done_o` rises, and it falls at that edge.
- R3: `done_o` rises exactly BIN_W clock edges after the edge that accepted the start, and it stays high for one cycle only.
- R4: When `done_o` is high, `bcd_o` holds the decimal value of the captured input. Digit k (k = 0 is the ones digit) sits in bits [4k+3:4k], each digit is 0..9, and unused upper digits are 0.
- R5: In an 8-bit instance, input 243 gives `bcd_o` = 12'h243 and input 8'b10011001 gives 12'h153.
- R6: A start strobe seen while `busy_o` is high is ignored, and the running conversion completes with the result of the value captured first.
- R7: In a 16-bit instance, 65244 gives 24'h065244, 0 gives 24'h000000 and 65535 gives 24'h065535.
- R8: `bcd_o` changes only at the edge where `done_o` rises, and it keeps its value until the next conversion completes.
- R9: A new start is accepted in the first cycle after `done_o` has pulsed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled only while idle |
| bin_i | input | BIN_W | Unsigned binary operand |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| bcd_o | output | 4*ceil(BIN_W/3) | Packed decimal digits, ones digit lowest |

## Verification
The embedded assertions rely on a few assumptions about the inputs. Reset is held low for at least one clock edge before operation. `bin_i` may take any unsigned value, because the digit field is wide enough that no bit is ever shifted out of its top. `start_i` may be asserted in any cycle. The stimulus holds reset for several cycles. It covers every 8-bit value and a spread of 16-bit values including both extremes, and it deliberately pulses `start_i` in the middle of a conversion to exercise the ignore path.

// File: rtl/bcd_conv_pkg.sv
// Package: shared sizing helpers and types for the sequential decimal converter.
// Assumes widths are positive.
package bcd_conv_pkg;

    // Number of 4-bit decimal digits needed for an n-bit unsigned value.
    function automatic int digit_count(input int n);
        return (n + 2) / 3;
    endfunction

    // Control state of the step sequencer.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } conv_state_e;

endpackage

// File: rtl/bcd_digit_adj.sv
// Module: bcd_digit_adj
// Applies the pre-shift correction to one decimal digit: values above 4 get 3 added.
// Assumes the incoming digit is a legal decimal digit (0..9), which keeps the sum within 4 bits.
module bcd_digit_adj (
    input  logic [3:0] dig_i,
    output logic [3:0] dig_o
);

    // Conditional add-3 correction.
    always_comb begin
        if (dig_i > 4'd4) begin
            dig_o = dig_i + 4'd3;
        end else begin
            dig_o = dig_i;
        end
    end

endmodule

// File: rtl/bcd_step_ctrl.sv
// Module: bcd_step_ctrl
// Sequences a conversion: accepts a start while idle, then counts BIN_W shift steps
// and flags the final one. Assumes BIN_W >= 2.
module bcd_step_ctrl
    import bcd_conv_pkg::*;
#(
    parameter int BIN_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic shift_o,
    output logic last_o,
    output logic busy_o,
    output logic done_o
);

    localparam int CW = $clog2(BIN_W + 1);
    localparam logic [CW-1:0] LAST_STEP = CW'(BIN_W - 1);

    conv_state_e   state_q;
    logic [CW-1:0] step_q;

    // Decode the step strobes from the current state.
    always_comb begin
        load_o  = (state_q == ST_IDLE) && start_i;
        shift_o = (state_q == ST_RUN);
        last_o  = (state_q == ST_RUN) && (step_q == LAST_STEP);
    end

    // State and step counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
        end else if (load_o) begin
            state_q <= ST_RUN;
            step_q  <= '0;
        end else if (last_o) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
        end else if (shift_o) begin
            step_q  <= step_q + CW'(1);
        end
    end

    // Completion pulse, registered one cycle after the final step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
        end else begin
            done_o <= last_o;
        end
    end

    assign busy_o = (state_q == ST_RUN);

    // R3: completion is a single-cycle pulse.
    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: a start seen during a run does not restart the step count.
    assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !last_o) |=> (busy_o && step_q != '0));

endmodule

// File: rtl/bcd_shift_datapath.sv
// Module: bcd_shift_datapath
// Holds the combined working register (decimal digits above, binary operand below),
// performs correction plus one-bit left shift per step, and captures the final digits.
// Assumes load and shift strobes are mutually exclusive.
module bcd_shift_datapath #(
    parameter int BIN_W  = 16,
    parameter int DIGITS = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic                  shift_i,
    input  logic                  last_i,
    input  logic [BIN_W-1:0]      bin_i,
    output logic [4*DIGITS-1:0]   bcd_o
);

    localparam int BCD_W  = 4 * DIGITS;
    localparam int WORK_W = BIN_W + BCD_W;

    logic [WORK_W-1:0] work_q;
    logic [WORK_W-1:0] adj_w;
    logic [WORK_W-1:0] shifted_w;

    // One correction cell per digit of the upper field.
    for (genvar d = 0; d < DIGITS; d++) begin : g_adj
        bcd_digit_adj u_adj (
            .dig_i (work_q[BIN_W + 4*d +: 4]),
            .dig_o (adj_w[BIN_W + 4*d +: 4])
        );

        // R4: every digit in the working field stays decimal while stepping.
        assert_digit_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
            shift_i |-> (work_q[BIN_W + 4*d +: 4] <= 4'd9));
    end

    // The operand field passes through uncorrected.
    assign adj_w[BIN_W-1:0] = work_q[BIN_W-1:0];

    // Left shift of the corrected register by one bit.
    assign shifted_w = {adj_w[WORK_W-2:0], 1'b0};

    // Working register: clear-and-load on start, step otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q <= '0;
        end else if (load_i) begin
            work_q <= {{BCD_W{1'b0}}, bin_i};
        end else if (shift_i) begin
            work_q <= shifted_w;
        end
    end

    // Result register: captures the digit field after the final shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcd_o <= '0;
        end else if (last_i) begin
            bcd_o <= shifted_w[WORK_W-1 -: BCD_W];
        end
    end

    // R4: the field is wide enough that no set bit leaves its top.
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |-> !adj_w[WORK_W-1]);

endmodule

// File: rtl/bcd_seq_conv.sv
// Module: bcd_seq_conv (top)
// Iterative unsigned binary to packed decimal converter, one shift per cycle.
// Assumes start_i is synchronous to clk and BIN_W >= 2.
module bcd_seq_conv
    import bcd_conv_pkg::*;
#(
    parameter int BIN_W = 16
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start_i,
    input  logic [BIN_W-1:0]                     bin_i,
    output logic                                 busy_o,
    output logic                                 done_o,
    output logic [4*digit_count(BIN_W)-1:0]      bcd_o
);

    localparam int DIGITS = digit_count(BIN_W);
    localparam int CW     = $clog2(BIN_W + 1);

    logic load_w;
    logic shift_w;
    logic last_w;

    bcd_step_ctrl #(
        .BIN_W (BIN_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load_w),
        .shift_o (shift_w),
        .last_o  (last_w),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    bcd_shift_datapath #(
        .BIN_W  (BIN_W),
        .DIGITS (DIGITS)
    ) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_w),
        .shift_i (shift_w),
        .last_i  (last_w),
        .bin_i   (bin_i),
        .bcd_o   (bcd_o)
    );

    // Latency observer: counts busy cycles since the last accepted start.
    logic [CW-1:0] lat_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (load_w) begin
            lat_q <= '0;
        end else if (busy_o) begin
            lat_q <= lat_q + CW'(1);
        end
    end

    // R3: completion arrives exactly BIN_W steps after acceptance.
    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lat_q == CW'(BIN_W)));

    // R2: busy drops only together with the completion pulse.
    assert_busy_until_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R8: the result bus moves only when a conversion completes.
    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(bcd_o));

endmodule

// File: tb/bcd_seq_conv_tb_top.sv
// Scoreboard bench: a driver task queues expected digits, monitors compare on done.
module bcd_seq_conv_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        st16 = 1'b0, st8 = 1'b0;
    logic [15:0] bin16 = '0;
    logic [7:0]  bin8 = '0;
    logic        busy16, done16, busy8, done8;
    logic [23:0] bcd16;
    logic [11:0] bcd8;

    bcd_seq_conv #(.BIN_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(st16), .bin_i(bin16),
        .busy_o(busy16), .done_o(done16), .bcd_o(bcd16));

    bcd_seq_conv #(.BIN_W(8)) dut8_i (
        .clk(clk), .rst_n(rst_n), .start_i(st8), .bin_i(bin8),
        .busy_o(busy8), .done_o(done8), .bcd_o(bcd8));

    int n_chk = 0;
    int n_fail = 0;
    logic [23:0] q16[$];
    logic [23:0] q8[$];
    string       tag16[$];
    string       tag8[$];

    // Reference: repeated division by ten.
    function automatic logic [23:0] ref_bcd(input int v);
        logic [23:0] r = '0;
        for (int i = 0; i < 6; i++) begin
            r[4*i +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitors: pop expected digits when a result appears.
    always @(negedge clk) begin
        if (rst_n && done16) begin
            if (q16.size() == 0) check("R4 unexpected done16", 24'h1, 24'h0);
            else check(tag16.pop_front(), bcd16, q16.pop_front());
        end
        if (rst_n && done8) begin
            if (q8.size() == 0) check("R4 unexpected done8", 24'h1, 24'h0);
            else check(tag8.pop_front(), {12'h0, bcd8}, q8.pop_front());
        end
    end

    // Driver: start one conversion, optionally poke start mid-run, check timing.
    task automatic convert(input bit wide, input int value, input bit poke, input string req);
        int cyc;
        @(negedge clk);
        while (wide ? busy16 : busy8) @(negedge clk);
        if (wide) begin
            st16 = 1'b1; bin16 = 16'(value); q16.push_back(ref_bcd(value)); tag16.push_back(req);
        end else begin
            st8 = 1'b1; bin8 = 8'(value); q8.push_back(ref_bcd(value)); tag8.push_back(req);
        end
        @(negedge clk);
        st16 = 1'b0; st8 = 1'b0;
        check("R2 busy after start", {23'h0, wide ? busy16 : busy8}, 24'h1);
        cyc = 0;
        while (!(wide ? done16 : done8) && cyc < 40) begin
            if (poke && cyc == 2) begin st16 = wide; st8 = !wide; bin16 = ~bin16; bin8 = ~bin8; end
            if (poke && cyc == 3) begin st16 = 1'b0; st8 = 1'b0; end
            @(negedge clk);
            cyc++;
        end
        check("R3 latency", 24'(cyc), wide ? 24'd16 : 24'd8);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        check("R1 reset busy16", {23'h0, busy16}, 24'h0);
        check("R1 reset done16", {23'h0, done16}, 24'h0);
        check("R1 reset bcd16", bcd16, 24'h0);
        check("R1 reset bcd8", {12'h0, bcd8}, 24'h0);
        rst_n = 1'b1;

        convert(1'b0, 243, 1'b0, "R5 243");
        convert(1'b0, 153, 1'b0, "R5 153");
        convert(1'b1, 65244, 1'b0, "R7 65244");
        convert(1'b1, 0, 1'b0, "R7 zero");
        convert(1'b1, 65535, 1'b0, "R7 max");

        // R8: result holds after completion.
        repeat (5) @(negedge clk);
        check("R8 hold", bcd16, 24'h065535);

        // R6: mid-run starts are dropped.
        convert(1'b1, 12345, 1'b1, "R6 ignore16");
        convert(1'b0, 99, 1'b1, "R6 ignore8");

        // R9: back-to-back start right after done.
        convert(1'b1, 40000, 1'b0, "R9 first");
        convert(1'b1, 7, 1'b0, "R9 second");

        // R4: exhaustive 8-bit sweep and a spread of 16-bit values.
        for (int v = 0; v < 256; v++) convert(1'b0, v, 1'b0, "R4 sweep8");
        for (int k = 0; k < 150; k++) convert(1'b1, int'($urandom_range(0, 65535)), 1'b0, "R4 rand16");

        repeat (4) @(negedge clk);
        check("R4 queue16 drained", 24'(q16.size()), 24'h0);
        check("R4 queue8 drained", 24'(q8.size()), 24'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule